// File: doc/BRIEF.md
# Link Pulse Polarity Detector

This block watches the receive pair of a 10BASE-T port while no frame is arriving and decides whether the two wires of the pair are swapped. The pair reaches the block as two digital comparator outputs. `rx_pos` is high during a positive excursion and `rx_neg` is high during a negative one. Each isolated link pulse is classified by its leading lobe as normal (positive first) or inverted (negative first). A lobe counts only if its width falls inside a sample-count window. Runs of like-classified pulses are counted.

After a run of inverted pulses the block enters the swapped mode. In that mode it drives `pol_fix` and exchanges the two comparator outputs before passing them on. The receive decoder downstream therefore keeps producing correct data on a miswired cable. At the same moment it sets a status flag that stays set until software acknowledges it with `flag_clr`. A run of normal pulses seen while swapped returns the block to the trusted mode. The status flag is not affected by that return.

The pulse shaper state machine has four states:
- `SCAN` waits for an excursion.
- `LEAD_POS` and `LEAD_NEG` measure the leading lobe.
- `SETTLE` waits for a quiet pair.

Its transitions are:
- SCAN→LEAD_POS or SCAN→LEAD_NEG when one comparator rises alone.
- LEAD_*→LEAD_* while the lobe lasts.
- LEAD_*→SCAN when the lobe ends onto a quiet pair.
- LEAD_*→SETTLE when the lobe ends onto the other comparator, runs too long, or frame activity starts.
- SCAN→SETTLE on frame activity.
- SETTLE→SCAN once activity has ended and both comparators are low.

The run state machine has two states:
- `TRUSTED` counts inverted pulses.
- `SWAPPED` counts normal pulses.

Its transitions are:
- TRUSTED→SWAPPED on the third consecutive inverted pulse.
- SWAPPED→TRUSTED on the third consecutive normal pulse.

Top module: `lpp_polarity_detect`

## Requirements
- R1: A pulse is inverted when its leading lobe has `rx_neg`=1 and `rx_pos`=0 for MIN_W..MAX_W consecutive samples (2..6 by default). A pulse is normal when the leading lobe has `rx_pos`=1 and `rx_neg`=0 for the same widths. Each pulse is reported once.
- R2: A leading lobe shorter than MIN_W or longer than MAX_W samples is not a pulse. It neither advances nor clears the current run.
- R3: In trusted mode, RUN_LEN (3) consecutive inverted pulses set both `pol_fix` and `pol_flag`.
- R4: In trusted mode, a normal pulse arriving before the run completes clears the inverted-pulse run to zero.
- R5: `pol_flag` stays set until `flag_clr` is high at a clock edge. Clearing it leaves `pol_fix` unchanged.
- R6: With `pol_fix`=0, `fixed_pos`=`rx_pos` and `fixed_neg`=`rx_neg`. With `pol_fix`=1, `fixed_pos`=`rx_neg` and `fixed_neg`=`rx_pos`.
- R7: In swapped mode, RUN_LEN consecutive normal pulses clear `pol_fix`, and `pol_flag` stays as it was. An inverted pulse in between restarts that run.
- R8: While `rx_busy`=1, no excursion is classified. A lobe in progress when `rx_busy` rises is discarded. After `rx_busy` falls, scanning resumes only once both comparator inputs are low.
- R9: After reset `pol_fix`=0, `pol_flag`=0, both runs are empty, and the data outputs pass straight through.
- R10: An opposite-sense lobe that directly follows a valid leading lobe belongs to the same pulse and is not classified on its own.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_pos | input | 1 | Positive-excursion comparator output |
| rx_neg | input | 1 | Negative-excursion comparator output |
| rx_busy | input | 1 | High while a frame is being received |
| flag_clr | input | 1 | Read strobe that clears the status flag |
| pol_flag | output | 1 | Latched reversed-polarity status |
| pol_fix | output | 1 | Swapped mode is active |
| fixed_pos | output | 1 | Polarity-corrected positive comparator |
| fixed_neg | output | 1 | Polarity-corrected negative comparator |

## Verification
The bench builds the block with its defaults: MIN_W=2, MAX_W=6 and RUN_LEN=3. With these values, lobes of 1 and 7 samples sit just outside the width window on either side, and lobes of 2 and 6 samples sit exactly on its edges. A three-pulse run is short enough that one stimulus table can walk a run reset, both mode changes and the restart of the normal run in a few hundred cycles. The directed part covers reset, the read strobe, the data swap, and frame activity that starts in the middle of a lobe.

// File: rtl/lpp_pkg.sv
package lpp_pkg;
    // Pulse shaper: where the leading lobe of the current pulse stands
    typedef enum logic [1:0] {
        SCAN     = 2'd0,
        LEAD_POS = 2'd1,
        LEAD_NEG = 2'd2,
        SETTLE   = 2'd3
    } shape_t;

    // Run tracker: which pulse sense is currently being counted
    typedef enum logic {
        TRUSTED = 1'b0,
        SWAPPED = 1'b1
    } pol_t;
endpackage

// File: rtl/lpp_shape.sv
module lpp_shape
    import lpp_pkg::*;
#(
    parameter int MIN_W = 2,
    parameter int MAX_W = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_pos,
    input  logic rx_neg,
    input  logic rx_busy,
    output logic pulse_vld,
    output logic pulse_inv
);
    localparam int WW = $clog2(MAX_W + 1);

    shape_t         cur, nxt;
    logic [WW-1:0]  width, nxt_width;
    logic           emit, emit_inv;
    logic           lead_hi;

    // The leading lobe continues while its own comparator is the only one high
    always_comb begin
        if (cur == LEAD_NEG) lead_hi = rx_neg & ~rx_pos;
        else                 lead_hi = rx_pos & ~rx_neg;
    end

    always_comb begin
        nxt       = cur;
        nxt_width = width;
        emit      = 1'b0;
        emit_inv  = 1'b0;
        unique case (cur)
            SCAN: begin
                if (rx_busy) begin
                    nxt = SETTLE;
                end else if (rx_pos & ~rx_neg) begin
                    nxt       = LEAD_POS;
                    nxt_width = WW'(1);
                end else if (rx_neg & ~rx_pos) begin
                    nxt       = LEAD_NEG;
                    nxt_width = WW'(1);
                end
            end
            LEAD_POS, LEAD_NEG: begin
                if (rx_busy) begin
                    nxt = SETTLE;                      // frame activity: drop lobe
                end else if (lead_hi) begin
                    if (width == WW'(MAX_W)) nxt = SETTLE;   // too long
                    else nxt_width = width + WW'(1);
                end else begin
                    emit     = (width >= WW'(MIN_W));
                    emit_inv = (cur == LEAD_NEG);
                    nxt      = (rx_pos | rx_neg) ? SETTLE : SCAN;
                end
            end
            SETTLE: begin
                if (!rx_busy && !rx_pos && !rx_neg) nxt = SCAN;
            end
            default: nxt = SCAN;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur   <= SCAN;
            width <= '0;
        end else begin
            cur   <= nxt;
            width <= nxt_width;
        end
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pulse_vld <= 1'b0;
            pulse_inv <= 1'b0;
        end else begin
            pulse_vld <= emit;
            pulse_inv <= emit_inv;
        end
    end

    AST_IDLE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_vld |-> !$past(rx_busy)); // R8
    AST_SINGLE_REPORT: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_vld |=> !pulse_vld); // R1
endmodule

// File: rtl/lpp_run.sv
module lpp_run
    import lpp_pkg::*;
#(
    parameter int RUN_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pulse_vld,
    input  logic pulse_inv,
    input  logic flag_clr,
    output logic pol_fix,
    output logic pol_flag
);
    localparam int CW = $clog2(RUN_LEN + 1);

    pol_t          mode, nxt_mode;
    logic [CW-1:0] run_cnt, nxt_cnt;
    logic          hit, miss, set_flag;

    // A hit is a pulse of the sense that would change the current mode
    always_comb begin
        hit  = pulse_vld && ((mode == TRUSTED) ? pulse_inv : !pulse_inv);
        miss = pulse_vld && !hit;
    end

    always_comb begin
        nxt_mode = mode;
        nxt_cnt  = run_cnt;
        set_flag = 1'b0;
        unique case (mode)
            TRUSTED: begin
                if (hit) begin
                    if (run_cnt == CW'(RUN_LEN - 1)) begin
                        nxt_mode = SWAPPED;
                        nxt_cnt  = '0;
                        set_flag = 1'b1;
                    end else begin
                        nxt_cnt = run_cnt + CW'(1);
                    end
                end else if (miss) begin
                    nxt_cnt = '0;
                end
            end
            SWAPPED: begin
                if (hit) begin
                    if (run_cnt == CW'(RUN_LEN - 1)) begin
                        nxt_mode = TRUSTED;
                        nxt_cnt  = '0;
                    end else begin
                        nxt_cnt = run_cnt + CW'(1);
                    end
                end else if (miss) begin
                    nxt_cnt = '0;
                end
            end
            default: nxt_mode = TRUSTED;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode    <= TRUSTED;
            run_cnt <= '0;
        end else begin
            mode    <= nxt_mode;
            run_cnt <= nxt_cnt;
        end
    end

    // Outputs: latched flag, mode indicator
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        pol_flag <= 1'b0;
        else if (set_flag) pol_flag <= 1'b1;
        else if (flag_clr) pol_flag <= 1'b0;
    end

    always_comb pol_fix = (mode == SWAPPED);

    AST_FIX_NEEDS_INVERTED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pol_fix) |-> $past(pulse_vld && pulse_inv)); // R3
    AST_FIX_RAISES_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pol_fix) |-> pol_flag); // R3
    AST_RELEASE_NEEDS_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pol_fix) |-> $past(pulse_vld && !pulse_inv)); // R7
    AST_FLAG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(pol_flag) && !$past(flag_clr)) |-> pol_flag); // R5
endmodule

// File: rtl/lpp_polarity_detect.sv
module lpp_polarity_detect #(
    parameter int MIN_W   = 2,
    parameter int MAX_W   = 6,
    parameter int RUN_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_pos,
    input  logic rx_neg,
    input  logic rx_busy,
    input  logic flag_clr,
    output logic pol_flag,
    output logic pol_fix,
    output logic fixed_pos,
    output logic fixed_neg
);
    logic pulse_vld, pulse_inv;

    lpp_shape #(.MIN_W(MIN_W), .MAX_W(MAX_W)) u_shape (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_pos   (rx_pos),
        .rx_neg   (rx_neg),
        .rx_busy  (rx_busy),
        .pulse_vld(pulse_vld),
        .pulse_inv(pulse_inv)
    );

    lpp_run #(.RUN_LEN(RUN_LEN)) u_run (
        .clk      (clk),
        .rst_n    (rst_n),
        .pulse_vld(pulse_vld),
        .pulse_inv(pulse_inv),
        .flag_clr (flag_clr),
        .pol_fix  (pol_fix),
        .pol_flag (pol_flag)
    );

    // Swapped wires: exchange the two comparator senses
    always_comb begin
        fixed_pos = pol_fix ? rx_neg : rx_pos;
        fixed_neg = pol_fix ? rx_pos : rx_neg;
    end

    AST_SWAP_ON_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (pol_fix && rx_pos && !rx_neg) |-> (fixed_neg && !fixed_pos)); // R6
endmodule

// File: tb/lpp_polarity_detect_test.sv
module lpp_polarity_detect_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_pos = 1'b0, rx_neg = 1'b0, rx_busy = 1'b0, flag_clr = 1'b0;
    logic pol_flag, pol_fix, fixed_pos, fixed_neg;
    int   n_chk = 0, n_bad = 0;
    bit   done = 1'b0;

    always #2.5 clk = ~clk;   // 200 MHz

    lpp_polarity_detect uut (
        .clk(clk), .rst_n(rst_n), .rx_pos(rx_pos), .rx_neg(rx_neg),
        .rx_busy(rx_busy), .flag_clr(flag_clr), .pol_flag(pol_flag),
        .pol_fix(pol_fix), .fixed_pos(fixed_pos), .fixed_neg(fixed_neg)
    );

    // Vector: [9] inverted lead, [8:5] lead width, [4:2] tail width,
    // [1] expected pol_fix, [0] expected pol_flag
    localparam int NV = 13;
    localparam logic [9:0] VEC [0:NV-1] = '{
        {1'b1, 4'd3, 3'd0, 1'b0, 1'b0},  // R1 inverted, run 1
        {1'b1, 4'd2, 3'd0, 1'b0, 1'b0},  // R1 min width, run 2
        {1'b0, 4'd4, 3'd0, 1'b0, 1'b0},  // R4 normal clears run
        {1'b1, 4'd6, 3'd0, 1'b0, 1'b0},  // R1 max width, run 1
        {1'b1, 4'd1, 3'd0, 1'b0, 1'b0},  // R2 too short
        {1'b1, 4'd7, 3'd0, 1'b0, 1'b0},  // R2 too long
        {1'b1, 4'd3, 3'd2, 1'b0, 1'b0},  // R10 tail ignored, run 2
        {1'b1, 4'd5, 3'd0, 1'b1, 1'b1},  // R3 third inverted
        {1'b0, 4'd3, 3'd0, 1'b1, 1'b1},  // R7 normal run 1
        {1'b1, 4'd3, 3'd0, 1'b1, 1'b1},  // R7 restart
        {1'b0, 4'd2, 3'd0, 1'b1, 1'b1},  // R7 normal run 1
        {1'b0, 4'd6, 3'd3, 1'b1, 1'b1},  // R7 R10 normal run 2
        {1'b0, 4'd4, 3'd0, 1'b0, 1'b1}   // R7 release, R5 flag kept
    };

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic smp(input logic p, input logic n);
        @(negedge clk);
        rx_pos = p;
        rx_neg = n;
    endtask

    task automatic pulse(input logic inv, input int w, input int tail);
        for (int i = 0; i < w; i++) smp(~inv, inv);
        for (int i = 0; i < tail; i++) smp(inv, ~inv);
        for (int i = 0; i < 5; i++) smp(1'b0, 1'b0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        rx_pos = 1'b0; rx_neg = 1'b0; rx_busy = 1'b0; flag_clr = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic strobe_clr();
        @(negedge clk);
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
    endtask

    initial begin
        do_reset();
        // R9 reset state
        chk("R9 pol_fix", pol_fix, 1'b0);
        chk("R9 pol_flag", pol_flag, 1'b0);
        rx_busy = 1'b1; rx_pos = 1'b1;
        #1;
        chk("R9 R6 pass pos", fixed_pos, 1'b1);
        chk("R9 R6 pass neg", fixed_neg, 1'b0);
        smp(1'b0, 1'b0);
        rx_busy = 1'b0;
        smp(1'b0, 1'b0);

        // Table walk
        for (int k = 0; k < NV; k++) begin
            pulse(VEC[k][9], int'(VEC[k][8:5]), int'(VEC[k][4:2]));
            chk($sformatf("R1-table v%0d pol_fix", k), pol_fix, VEC[k][1]);
            chk($sformatf("R3-table v%0d pol_flag", k), pol_flag, VEC[k][0]);
        end

        // R5 read strobe clears the flag
        strobe_clr();
        chk("R5 flag cleared", pol_flag, 1'b0);
        for (int i = 0; i < 3; i++) pulse(1'b1, 3, 0);
        chk("R3 fix again", pol_fix, 1'b1);
        chk("R3 flag again", pol_flag, 1'b1);
        strobe_clr();
        chk("R5 flag cleared in swap", pol_flag, 1'b0);
        chk("R5 fix kept", pol_fix, 1'b1);

        // R6 swap, during busy so nothing is classified
        @(negedge clk);
        rx_busy = 1'b1; rx_pos = 1'b1; rx_neg = 1'b0;
        #1;
        chk("R6 swapped pos", fixed_pos, 1'b0);
        chk("R6 swapped neg", fixed_neg, 1'b1);
        smp(1'b0, 1'b1);
        #1;
        chk("R6 swapped pos b", fixed_pos, 1'b1);
        smp(1'b0, 1'b0);
        rx_busy = 1'b0;
        smp(1'b0, 1'b0);

        // R9 reset while swapped
        do_reset();
        chk("R9 fix after reset", pol_fix, 1'b0);
        chk("R9 flag after reset", pol_flag, 1'b0);

        // R8 pulses during busy are ignored
        @(negedge clk); rx_busy = 1'b1;
        for (int i = 0; i < 3; i++) pulse(1'b1, 3, 0);
        @(negedge clk); rx_busy = 1'b0;
        smp(1'b0, 1'b0);
        chk("R8 busy pulses ignored", pol_fix, 1'b0);
        pulse(1'b1, 3, 0);
        pulse(1'b1, 3, 0);
        // lobe cut by busy rising mid-way
        smp(1'b0, 1'b1);
        smp(1'b0, 1'b1);
        rx_busy = 1'b1;
        smp(1'b0, 1'b1);
        smp(1'b0, 1'b0);
        // busy falls while the pair is still active: must not start a lobe
        smp(1'b0, 1'b1);
        rx_busy = 1'b0;
        smp(1'b0, 1'b1);
        smp(1'b0, 1'b1);
        for (int i = 0; i < 5; i++) smp(1'b0, 1'b0);
        chk("R8 cut lobe discarded", pol_fix, 1'b0);
        pulse(1'b1, 4, 0);
        chk("R8 run resumes", pol_fix, 1'b1);
        chk("R8 flag follows", pol_flag, 1'b1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule